// File: doc/BRIEF.md
# Write Guard and Status Register

This block sits between the command decoder of a serial non-volatile memory and its programming engine. It keeps the write-arm latch and a two-bit guard level, builds the status byte returned by a status read, and tells the programming engine whether a data write to a given 9-bit byte address may go ahead. Its inputs are single-cycle command strobes from the decoder (arm, disarm, and guard-level commit with its data byte), the busy level and completion strobes of the programming engine, and the level of an active-low protect pin.

The guard level splits the byte address space into protected and writable regions. Level 0 protects nothing. Level 1 protects the top quarter (0x180 to 0x1FF). Level 2 protects the top half (0x100 to 0x1FF). Level 3 protects every address. The guard level is held in registers whose reset value is a parameter. It models retained storage, so clearing the arm latch never changes it.

All outputs are registered. The state and inputs sampled at a clock edge appear at the outputs just after that same edge.

Top module: `write_guard_status`

## Requirements
- R1: When the engine is not busy, the status byte reads bit 0 = 0 (idle), bit 1 = arm latch, bit 2 = guard level bit 0, bit 3 = guard level bit 1, and bits 7 to 4 = 0. Outputs reflect the state and inputs sampled at the most recent clock edge.
- R2: The guard level selects the protected addresses: 0 gives none, 1 gives 0x180 to 0x1FF, 2 gives 0x100 to 0x1FF, and 3 gives 0x000 to 0x1FF.
- R3: The arm latch is 0 after reset and is cleared by the disarm strobe. When arm and disarm arrive in the same cycle, disarm wins.
- R4: The arm strobe sets the latch only while the protect pin is high. In any cycle where the protect pin is low, the latch is cleared.
- R5: A completion strobe from either a data program cycle or a guard-level program cycle clears the arm latch and leaves the guard level unchanged.
- R6: While the engine is busy, the status byte reads 0xFF.
- R7: A guard-level commit updates the guard level from data bits 3:2 only when the latch is set and the protect pin is high. All other data bits are ignored. Otherwise the guard level is unchanged.
- R8: The write-permitted output is 1 only when the protect pin is high, the latch is set, and the queried address lies outside the protected range.
- R9: After reset, the guard level equals the parameter RST_LEVEL, which defaults to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_pin_n | input | 1 | Active-low protect pin level |
| cmd_arm | input | 1 | Arm strobe, one cycle |
| cmd_disarm | input | 1 | Disarm strobe, one cycle |
| cmd_lvl_commit | input | 1 | Guard-level commit strobe, one cycle |
| lvl_data | input | 8 | Data byte carried with the commit |
| eng_busy | input | 1 | Programming engine busy level |
| eng_done_data | input | 1 | Data program cycle completed, one cycle |
| eng_done_lvl | input | 1 | Guard-level program cycle completed, one cycle |
| query_addr | input | 9 | Byte address being checked |
| status_byte | output | 8 | Registered status byte |
| write_ok | output | 1 | Registered write-permitted flag for query_addr |

## Verification
The assertions assume that command and completion inputs are one-cycle strobes synchronous to clk. They also assume the protect pin is already synchronised, so its level sampled at an edge is the level that applies. The stimulus drives every input shortly after a rising edge and releases each strobe after one cycle, so each strobe is seen at exactly one edge. The one exception is the deliberate arm-plus-disarm collision. The address sweep holds each guard level steady while all 512 addresses pass, so every protect-region boundary is crossed under a stable latch.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int STATUS_W = 8;
  localparam int LVL_W    = 2;
  typedef logic [LVL_W-1:0] guard_lvl_t;
  typedef enum logic [LVL_W-1:0] {
    LVL_OPEN    = 2'd0,
    LVL_QUARTER = 2'd1,
    LVL_HALF    = 2'd2,
    LVL_ALL     = 2'd3
  } guard_mode_e;
endpackage

// File: rtl/wg_arm_latch.sv
module wg_arm_latch (
  input  logic clk,
  input  logic rst,
  input  logic prot_pin_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic done_pulse,
  output logic arm_d,
  output logic arm_q
);
  always_comb begin
    if (!prot_pin_n || clr_req || done_pulse) arm_d = 1'b0;
    else if (set_req)                         arm_d = 1'b1;
    else                                      arm_d = arm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) arm_q <= 1'b0;
    else     arm_q <= arm_d;
  end

  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> !arm_q); // R3
  AST_PIN_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !prot_pin_n |=> !arm_q); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !arm_q); // R5
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    (!arm_q && !set_req) |=> !arm_q); // R4
endmodule

// File: rtl/wg_level_reg.sv
module wg_level_reg
  import wg_pkg::*;
#(
  parameter guard_lvl_t RST_LEVEL = 2'd0,
  parameter int         LVL_LSB   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic             allow,
  input  logic [7:0]       data,
  output guard_lvl_t       lvl_d,
  output guard_lvl_t       lvl_q
);
  always_comb begin
    lvl_d = lvl_q;
    if (commit && allow) lvl_d = data[LVL_LSB +: LVL_W];
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= RST_LEVEL;
    else     lvl_q <= lvl_d;
  end

  AST_LVL_HELD: assert property (@(posedge clk) disable iff (rst)
    !(commit && allow) |=> $stable(lvl_q)); // R7
endmodule

// File: rtl/wg_range_check.sv
module wg_range_check
  import wg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  guard_lvl_t        lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1) << (ADDR_W-1);
  localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(3) << (ADDR_W-2);

  always_comb begin
    unique case (guard_mode_e'(lvl))
      LVL_OPEN:    hit = 1'b0;
      LVL_QUARTER: hit = (addr >= QUARTER_BASE);
      LVL_HALF:    hit = (addr >= HALF_BASE);
      LVL_ALL:     hit = 1'b1;
      default:     hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/write_guard_status.sv
module write_guard_status
  import wg_pkg::*;
#(
  parameter int         ADDR_W    = 9,
  parameter guard_lvl_t RST_LEVEL = 2'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_pin_n,
  input  logic              cmd_arm,
  input  logic              cmd_disarm,
  input  logic              cmd_lvl_commit,
  input  logic [7:0]        lvl_data,
  input  logic              eng_busy,
  input  logic              eng_done_data,
  input  logic              eng_done_lvl,
  input  logic [ADDR_W-1:0] query_addr,
  output logic [7:0]        status_byte,
  output logic              write_ok
);
  localparam int PAD_W = STATUS_W - LVL_W - 2;

  logic       arm_d, arm_q;
  guard_lvl_t lvl_d, lvl_q;
  logic       prot_hit;
  logic       lvl_allow;

  assign lvl_allow = arm_q && prot_pin_n;

  wg_arm_latch u_arm (
    .clk        (clk),
    .rst        (rst),
    .prot_pin_n (prot_pin_n),
    .set_req    (cmd_arm),
    .clr_req    (cmd_disarm),
    .done_pulse (eng_done_data | eng_done_lvl),
    .arm_d      (arm_d),
    .arm_q      (arm_q)
  );

  wg_level_reg #(.RST_LEVEL(RST_LEVEL), .LVL_LSB(2)) u_lvl (
    .clk    (clk),
    .rst    (rst),
    .commit (cmd_lvl_commit),
    .allow  (lvl_allow),
    .data   (lvl_data),
    .lvl_d  (lvl_d),
    .lvl_q  (lvl_q)
  );

  wg_range_check #(.ADDR_W(ADDR_W)) u_rng (
    .lvl  (lvl_d),
    .addr (query_addr),
    .hit  (prot_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_byte <= {{PAD_W{1'b0}}, RST_LEVEL, 1'b0, 1'b0};
      write_ok    <= 1'b0;
    end else begin
      status_byte <= eng_busy ? {STATUS_W{1'b1}}
                              : {{PAD_W{1'b0}}, lvl_d, arm_d, 1'b0};
      write_ok    <= prot_pin_n && arm_d && !prot_hit;
    end
  end

  AST_BUSY_MASK: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> (status_byte == 8'hFF)); // R6
  AST_PIN_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !prot_pin_n |=> !write_ok); // R8
  AST_DISARM_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmd_disarm |=> !write_ok); // R8
  AST_IDLE_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |=> (status_byte[7:4] == 4'h0 && !status_byte[0])); // R1
endmodule

// File: tb/sim_write_guard_status.sv
module sim_write_guard_status;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prot_pin_n = 1'b1;
  logic       cmd_arm = 1'b0, cmd_disarm = 1'b0, cmd_lvl_commit = 1'b0;
  logic [7:0] lvl_data = 8'h00;
  logic       eng_busy = 1'b0, eng_done_data = 1'b0, eng_done_lvl = 1'b0;
  logic [8:0] query_addr = 9'd0;
  logic [7:0] status_byte, status_b;
  logic       write_ok, write_ok_b;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  write_guard_status u0 (
    .clk(clk), .rst(rst), .prot_pin_n(prot_pin_n), .cmd_arm(cmd_arm),
    .cmd_disarm(cmd_disarm), .cmd_lvl_commit(cmd_lvl_commit), .lvl_data(lvl_data),
    .eng_busy(eng_busy), .eng_done_data(eng_done_data), .eng_done_lvl(eng_done_lvl),
    .query_addr(query_addr), .status_byte(status_byte), .write_ok(write_ok));

  write_guard_status #(.RST_LEVEL(2'd2)) u1 (
    .clk(clk), .rst(rst), .prot_pin_n(prot_pin_n), .cmd_arm(1'b0),
    .cmd_disarm(1'b0), .cmd_lvl_commit(1'b0), .lvl_data(8'h00),
    .eng_busy(1'b0), .eng_done_data(1'b0), .eng_done_lvl(1'b0),
    .query_addr(9'd0), .status_byte(status_b), .write_ok(write_ok_b));

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit is_protected(input int lvl, input int a);
    case (lvl)
      0: return 1'b0;
      1: return a >= 384;
      2: return a >= 256;
      default: return 1'b1;
    endcase
  endfunction

  task automatic pulse_arm();
    cmd_arm = 1'b1; step(); cmd_arm = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(); step(); step();
    rst = 1'b0;
    step();
    check("R1 R3 reset status", status_byte, 8'h00);
    check("R8 reset write_ok", write_ok, 0);
    check("R9 reset level param", status_b, 8'h08);

    // R4: arm ignored with pin low
    prot_pin_n = 1'b0; pulse_arm();
    check("R4 arm blocked", status_byte, 8'h00);
    prot_pin_n = 1'b1; pulse_arm();
    check("R4 arm sets", status_byte, 8'h02);
    prot_pin_n = 1'b0; step(); prot_pin_n = 1'b1; step();
    check("R4 pin low clears", status_byte, 8'h00);

    // R3: disarm wins, disarm clears
    cmd_arm = 1'b1; cmd_disarm = 1'b1; step(); cmd_arm = 1'b0; cmd_disarm = 1'b0;
    check("R3 disarm wins", status_byte, 8'h00);
    pulse_arm();
    cmd_disarm = 1'b1; step(); cmd_disarm = 1'b0;
    check("R3 disarm clears", status_byte, 8'h00);

    // R7: commit without arm ignored
    lvl_data = 8'hFF; cmd_lvl_commit = 1'b1; step(); cmd_lvl_commit = 1'b0;
    check("R7 commit unarmed ignored", status_byte, 8'h00);
    pulse_arm();
    lvl_data = 8'hF7; cmd_lvl_commit = 1'b1; prot_pin_n = 1'b0; step();
    cmd_lvl_commit = 1'b0; prot_pin_n = 1'b1; step();
    check("R7 commit pin low ignored", status_byte, 8'h00);
    pulse_arm();
    lvl_data = 8'hF7; cmd_lvl_commit = 1'b1; step(); cmd_lvl_commit = 1'b0;
    check("R7 commit takes bits 3:2", status_byte, 8'h06);

    // R5: completion clears latch, keeps level
    eng_done_lvl = 1'b1; step(); eng_done_lvl = 1'b0;
    check("R5 level done clears", status_byte, 8'h04);
    pulse_arm();
    eng_done_data = 1'b1; step(); eng_done_data = 1'b0;
    check("R5 data done clears", status_byte, 8'h04);

    // R6: busy mask
    eng_busy = 1'b1; step();
    check("R6 busy reads FF", status_byte, 8'hFF);
    eng_busy = 1'b0; step();
    check("R6 busy released", status_byte, 8'h04);

    // R2 / R8 sweep over every level and address
    for (int lvl = 0; lvl < 4; lvl++) begin
      pulse_arm();
      lvl_data = {4'hA, lvl[1:0], 2'b11};
      cmd_lvl_commit = 1'b1; step(); cmd_lvl_commit = 1'b0;
      eng_done_lvl = 1'b1; step(); eng_done_lvl = 1'b0;
      pulse_arm();
      check("R1 R7 level readback", status_byte, {4'h0, lvl[1:0], 2'b10});
      for (int a = 0; a < 512; a++) begin
        query_addr = a[8:0];
        step();
        check("R2 R8 write_ok sweep", write_ok, is_protected(lvl, a) ? 0 : 1);
      end
      query_addr = 9'd0;
      prot_pin_n = 1'b0; step();
      check("R8 pin low blocks", write_ok, 0);
      prot_pin_n = 1'b1; pulse_arm();
      cmd_disarm = 1'b1; step(); cmd_disarm = 1'b0;
      check("R8 disarmed blocks", write_ok, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule